// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command register that sits between the external parallel bus of a NOR-style memory and its program/erase sequencer. It samples chip-enable, write-enable and output-enable once per clock and turns each completed write cycle into one internal write event. It then matches those events against fixed unlock patterns. A matching sequence produces a one-cycle program or chip-erase strobe for the sequencer, or it moves the decoder into an identification mode or a secure-region mode. A wrong step at any point quietly drops the partial sequence.

The decoder also decides what a read returns. From the current mode and the read address it drives a read-source select: normal array, identification code, secure area, or sequencer status after a failure. In identification mode it supplies the code word itself. All bus pins and control inputs are plain levels with no handshake. The bus is assumed to be already synchronous to `clk`, so nothing is buffered and nothing can be back-pressured.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset `rd_sel` is 0 (array), `id_word` is 0 and both strobes are low. Reset also leaves secure-region mode.
- R2: A write cycle is active while `bus_ce_n`=0, `bus_we_n`=0 and `bus_oe_n`=1. The address is taken from the first active sample and the data from the last. The write takes effect one cycle after the cycle ends, so the strobe or mode change shows two clock edges after the first inactive sample.
- R3: The writes 0xAA to 0x555, 0x55 to 0x2AA and 0xA0 to 0x555, followed by any write, give a one-cycle `prog_req`. `prog_addr` and `prog_data` carry the address and data of that last write. Unlock addresses are compared on the low 11 bits and command data on the low 8 bits.
- R4: While `accel_en` is 1, a single write of 0xA0 to 0x555 from the idle state arms programming directly.
- R5: The six writes AA@555, 55@2AA, 80@555, AA@555, 55@2AA, 10@555 give a one-cycle `erase_req`. `prog_req` and `erase_req` are never high together.
- R6: The unlock pair followed by 0x90@555 enters identification mode, and `rd_sel` becomes 1. The mode persists across any number of reads. `id_word` is 0x00C2 at offset 0x00, 0x22FE at 0x01, and 0x0088 at 0x03 (factory-locked) or 0x0008 (not locked). Other offsets give 0. The offset is `bus_addr[7:0]`.
- R7: A write whose low data byte is 0xF0, at any address, clears a partial sequence and leaves identification mode. It does not leave secure-region mode. Once a program address write is expected, 0xF0 is taken as program data instead.
- R8: A wrong address, wrong data or out-of-order step clears the partial sequence without any strobe. The current mode is kept.
- R9: The unlock pair followed by 0x88@555 enters secure-region mode. In that mode `rd_sel` is 2 for read addresses below 0x200 and 0 otherwise. The unlock pair, 0x90@555 and then 0x00 at any address, returns to array mode.
- R10: A high `seq_fail` puts the decoder in failure mode, where `rd_sel` is 3. Only a 0xF0 write leaves it, and all other writes are ignored. If `seq_fail` and a write fall in the same cycle, failure mode wins.
- R11: A write that takes effect while `seq_busy` is 1 is ignored completely, including 0xF0.
- R12: After a program or erase strobe, identification mode falls back to array mode. Secure-region mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | 20 | Word address for writes and reads |
| bus_wdata | input | 16 | Write data |
| seq_busy | input | 1 | Sequencer is running an operation |
| seq_fail | input | 1 | Sequencer reports a timed-out operation |
| accel_en | input | 1 | Skip unlock cycles for programming |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | 20 | Address to program |
| prog_data | output | 16 | Data to program |
| erase_req | output | 1 | One-cycle chip-erase request |
| rd_sel | output | 2 | Read source: 0 array, 1 ident, 2 secure, 3 status |
| id_word | output | 16 | Identification code for the current read address |

## Verification
A failure report from the sequencer and a completed 0xF0 write can land on the same clock edge. One would enter failure mode and the other would leave it. The bench raises `seq_fail` for exactly the cycle in which that write takes effect, then reads `rd_sel`. The result is correct only if it shows status (3), and a later plain 0xF0 write must still return the decoder to array mode.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_SECURE = 2'd2,
    RD_STATUS = 2'd3
  } rd_sel_e;

  typedef enum logic [1:0] {
    M_ARRAY  = 2'd0,
    M_IDENT  = 2'd1,
    M_SECURE = 2'd2,
    M_FAIL   = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_UNL1,
    S_UNL2,
    S_PGM,
    S_ER1,
    S_ER2,
    S_ER3,
    S_SEXIT
  } seq_e;

  localparam logic [7:0] K_FIRST   = 8'hAA;
  localparam logic [7:0] K_SECOND  = 8'h55;
  localparam logic [7:0] K_PROG    = 8'hA0;
  localparam logic [7:0] K_IDENT   = 8'h90;
  localparam logic [7:0] K_SECURE  = 8'h88;
  localparam logic [7:0] K_ERSETUP = 8'h80;
  localparam logic [7:0] K_ERCHIP  = 8'h10;
  localparam logic [7:0] K_ABORT   = 8'hF0;
  localparam logic [7:0] K_SEXIT   = 8'h00;

endpackage

// File: rtl/ncd_bus_capture.sv
module ncd_bus_capture #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              act;
  logic              act_q;
  logic [ADDR_W-1:0] addr_l;
  logic [DATA_W-1:0] data_l;

  // a write is live only with both strobes low and the output driver off
  assign act = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_stb  <= 1'b0;
      addr_l  <= '0;
      data_l  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      act_q  <= act;
      wr_stb <= act_q && !act;
      if (act && !act_q) addr_l <= addr;   // later of the two falling edges
      if (act)           data_l <= wdata;  // keeps the value at the first rising edge
      if (act_q && !act) begin
        wr_addr <= addr_l;
        wr_data <= data_l;
      end
    end
  end

  assert_commit_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(act_q) && !$past(act)))
    else $error("R2 write event without an ended cycle");

  assert_commit_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb)
    else $error("R2 write event longer than one cycle");

endmodule

// File: rtl/ncd_seq_fsm.sv
module ncd_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int CMP_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              fail,
  input  logic              accel,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output mode_e             mode
);

  localparam logic [CMP_W-1:0] A_FIRST  = CMP_W'(12'h555);
  localparam logic [CMP_W-1:0] A_SECOND = CMP_W'(12'h2AA);

  seq_e       seq;
  logic       take;
  logic       at_first;
  logic       at_second;
  logic [7:0] cmd;
  logic       is_abort;

  assign take      = wr_stb && !busy;
  assign cmd       = wr_data[7:0];
  assign at_first  = (wr_addr[CMP_W-1:0] == A_FIRST);
  assign at_second = (wr_addr[CMP_W-1:0] == A_SECOND);
  assign is_abort  = (cmd == K_ABORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq       <= S_IDLE;
      mode      <= M_ARRAY;
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
      if (fail) begin
        mode <= M_FAIL;
        seq  <= S_IDLE;
      end else if (take) begin
        if (mode == M_FAIL) begin
          if (is_abort) mode <= M_ARRAY;
        end else if (is_abort && seq != S_PGM) begin
          seq <= S_IDLE;
          if (mode == M_IDENT) mode <= M_ARRAY;
        end else begin
          unique case (seq)
            S_IDLE: begin
              if (at_first && cmd == K_FIRST)             seq <= S_UNL1;
              else if (accel && at_first && cmd == K_PROG) seq <= S_PGM;
              else                                         seq <= S_IDLE;
            end
            S_UNL1: seq <= (at_second && cmd == K_SECOND) ? S_UNL2 : S_IDLE;
            S_UNL2: begin
              seq <= S_IDLE;
              if (at_first) begin
                if (cmd == K_PROG)         seq <= S_PGM;
                else if (cmd == K_ERSETUP) seq <= S_ER1;
                else if (cmd == K_SECURE)  mode <= M_SECURE;
                else if (cmd == K_IDENT) begin
                  if (mode == M_SECURE) seq <= S_SEXIT;
                  else                  mode <= M_IDENT;
                end
              end
            end
            S_PGM: begin
              prog_req  <= 1'b1;
              prog_addr <= wr_addr;
              prog_data <= wr_data;
              seq       <= S_IDLE;
              if (mode == M_IDENT) mode <= M_ARRAY;
            end
            S_ER1: seq <= (at_first && cmd == K_FIRST) ? S_ER2 : S_IDLE;
            S_ER2: seq <= (at_second && cmd == K_SECOND) ? S_ER3 : S_IDLE;
            S_ER3: begin
              seq <= S_IDLE;
              if (at_first && cmd == K_ERCHIP) begin
                erase_req <= 1'b1;
                if (mode == M_IDENT) mode <= M_ARRAY;
              end
            end
            S_SEXIT: begin
              seq <= S_IDLE;
              if (cmd == K_SEXIT) mode <= M_ARRAY;
            end
            default: seq <= S_IDLE;
          endcase
        end
      end
    end
  end

  assert_no_dual_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && erase_req))
    else $error("R5 program and erase strobes together");

  assert_prog_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> !prog_req)
    else $error("R3 program strobe longer than one cycle");

  assert_erase_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> $past(wr_stb))
    else $error("R5 erase strobe without a write event");

  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && busy && !fail) |=> (!prog_req && !erase_req && $stable(mode) && $stable(seq)))
    else $error("R11 write acted on while busy");

  assert_fail_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> (mode == M_FAIL))
    else $error("R10 failure report not taken");

endmodule

// File: rtl/ncd_read_map.sv
module ncd_read_map
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int DATA_W         = 16,
  parameter int SEC_WORDS      = 512,
  parameter int ID_OFS_W       = 8,
  parameter bit FACTORY_LOCKED = 1'b1
) (
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] id_word
);

  localparam int SEC_AW = $clog2(SEC_WORDS);

  logic [DATA_W-1:0]   lock_code;
  logic [ID_OFS_W-1:0] ofs;
  logic                in_secure;

  generate
    if (FACTORY_LOCKED) begin : g_locked
      assign lock_code = DATA_W'(16'h0088);
    end else begin : g_open
      assign lock_code = DATA_W'(16'h0008);
    end
  endgenerate

  assign ofs       = rd_addr[ID_OFS_W-1:0];
  assign in_secure = (rd_addr[ADDR_W-1:SEC_AW] == '0);

  always_comb begin
    id_word = '0;
    if (mode == M_IDENT) begin
      case (ofs)
        ID_OFS_W'(0): id_word = DATA_W'(16'h00C2);
        ID_OFS_W'(1): id_word = DATA_W'(16'h22FE);
        ID_OFS_W'(3): id_word = lock_code;
        default:      id_word = '0;
      endcase
    end
  end

  always_comb begin
    unique case (mode)
      M_IDENT:  rd_sel = RD_IDENT;
      M_SECURE: rd_sel = in_secure ? RD_SECURE : RD_ARRAY;
      M_FAIL:   rd_sel = RD_STATUS;
      default:  rd_sel = RD_ARRAY;
    endcase
  end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W         = 20,
  parameter int DATA_W         = 16,
  parameter int CMP_W          = 11,
  parameter int SEC_WORDS      = 512,
  parameter int ID_OFS_W       = 8,
  parameter bit FACTORY_LOCKED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              seq_busy,
  input  logic              seq_fail,
  input  logic              accel_en,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_req,
  output logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] id_word
);

  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  mode_e             mode;

  ncd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (bus_ce_n),
    .we_n    (bus_we_n),
    .oe_n    (bus_oe_n),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  ncd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .busy      (seq_busy),
    .fail      (seq_fail),
    .accel     (accel_en),
    .prog_req  (prog_req),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .erase_req (erase_req),
    .mode      (mode)
  );

  ncd_read_map #(
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W),
    .SEC_WORDS      (SEC_WORDS),
    .ID_OFS_W       (ID_OFS_W),
    .FACTORY_LOCKED (FACTORY_LOCKED)
  ) u_map (
    .mode    (mode),
    .rd_addr (bus_addr),
    .rd_sel  (rd_sel),
    .id_word (id_word)
  );

  assert_reset_array_R1: assert property (@(posedge clk)
    !rst_n |=> (mode == M_ARRAY && !prog_req && !erase_req))
    else $error("R1 reset did not return to array mode");

endmodule

// File: tb/tb_nor_cmd_decoder.sv
`timescale 1ns/1ps
module tb_nor_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
  logic [19:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        seq_busy = 1'b0, seq_fail = 1'b0, accel_en = 1'b0;
  logic        prog_req, erase_req;
  logic [19:0] prog_addr;
  logic [15:0] prog_data;
  logic [1:0]  rd_sel;
  logic [15:0] id_word;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nor_cmd_decoder dut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .seq_busy(seq_busy), .seq_fail(seq_fail), .accel_en(accel_en),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_req(erase_req), .rd_sel(rd_sel), .id_word(id_word)
  );

  // {address, data, strobe kind (0 none,1 program,2 erase), rd_sel at read address 0x010}
  localparam int NV = 41;
  localparam logic [39:0] VEC [NV] = '{
    {20'h00555,16'h00AA,2'd0,2'd0}, {20'h002AA,16'h0055,2'd0,2'd0},
    {20'h00555,16'h00A0,2'd0,2'd0}, {20'h01234,16'hBEEF,2'd1,2'd0},
    {20'h00555,16'h00AA,2'd0,2'd0}, {20'h002AA,16'h0055,2'd0,2'd0},
    {20'h00555,16'h0080,2'd0,2'd0}, {20'h00555,16'h00AA,2'd0,2'd0},
    {20'h002AA,16'h0055,2'd0,2'd0}, {20'h00555,16'h0010,2'd2,2'd0},
    {20'h00555,16'h00AA,2'd0,2'd0}, {20'h002AA,16'h0055,2'd0,2'd0},
    {20'h00555,16'h0090,2'd0,2'd1}, {20'h00777,16'h00F0,2'd0,2'd0},
    {20'h00555,16'h00AA,2'd0,2'd0}, {20'h002AA,16'h0055,2'd0,2'd0},
    {20'h00555,16'h0088,2'd0,2'd2}, {20'h00555,16'h00AA,2'd0,2'd2},
    {20'h002AA,16'h0055,2'd0,2'd2}, {20'h00555,16'h0090,2'd0,2'd2},
    {20'h00003,16'h0000,2'd0,2'd0}, {20'h00555,16'h00AA,2'd0,2'd0},
    {20'h002AB,16'h0055,2'd0,2'd0}, {20'h00555,16'h00A0,2'd0,2'd0},
    {20'h00100,16'h1234,2'd0,2'd0}, {20'hF8555,16'h00AA,2'd0,2'd0},
    {20'h402AA,16'h0055,2'd0,2'd0}, {20'h00555,16'h00A0,2'd0,2'd0},
    {20'h00042,16'h5A5A,2'd1,2'd0}, {20'h00555,16'h00AA,2'd0,2'd0},
    {20'h002AA,16'h0055,2'd0,2'd0}, {20'h00555,16'h0080,2'd0,2'd0},
    {20'h00555,16'h00F0,2'd0,2'd0}, {20'h00555,16'h0010,2'd0,2'd0},
    {20'h00555,16'h00AA,2'd0,2'd0}, {20'h002AA,16'h0055,2'd0,2'd0},
    {20'h00555,16'h0090,2'd0,2'd1}, {20'h00555,16'h00AA,2'd0,2'd1},
    {20'h002AA,16'h0055,2'd0,2'd1}, {20'h00555,16'h00A0,2'd0,2'd1},
    {20'hABCDE,16'h0F0F,2'd1,2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // starts and returns at a falling clock edge; the effect is visible on return
  task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic fail_at_commit);
    bus_addr = a; bus_wdata = d; bus_ce_n = 1'b0; bus_we_n = 1'b0;
    @(posedge clk); @(negedge clk);
    bus_we_n = 1'b1; bus_ce_n = 1'b1;
    @(posedge clk); @(negedge clk);
    seq_fail = fail_at_commit;
    @(posedge clk); @(negedge clk);
    seq_fail = 1'b0;
  endtask

  task automatic unlock_cmd(input logic [7:0] c);
    wr(20'h00555, 16'h00AA, 1'b0);
    wr(20'h002AA, 16'h0055, 1'b0);
    wr(20'h00555, {8'h00, c}, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [19:0] a;
    logic [15:0] d;
    logic [1:0]  k, s;

    do_reset();
    bus_addr = 20'h00010; #1;
    chk("R1 reset rd_sel", rd_sel, 0);
    chk("R1 reset strobes", {prog_req, erase_req}, 0);
    chk("R1 reset id_word", id_word, 0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {a, d, k, s} = VEC[i];
      wr(a, d, 1'b0);
      bus_addr = 20'h00010; #1;
      chk($sformatf("R3 R8 R4 prog strobe vec %0d", i), prog_req, k == 2'd1);
      chk($sformatf("R5 erase strobe vec %0d", i), erase_req, k == 2'd2);
      chk($sformatf("R6 R9 R7 R12 rd_sel vec %0d", i), rd_sel, s);
      if (k == 2'd1) begin
        chk($sformatf("R3 prog_addr vec %0d", i), prog_addr, a);
        chk($sformatf("R3 prog_data vec %0d", i), prog_data, d);
      end
      @(negedge clk);
    end

    // R6 identification codes at several offsets, repeated reads
    unlock_cmd(8'h90);
    bus_addr = 20'h12300; #1; chk("R6 id offset 00", id_word, 16'h00C2);
    bus_addr = 20'h45601; #1; chk("R6 id offset 01", id_word, 16'h22FE);
    bus_addr = 20'h00003; #1; chk("R6 id offset 03", id_word, 16'h0088);
    bus_addr = 20'h00002; #1; chk("R6 id offset 02", id_word, 16'h0000);
    bus_addr = 20'h12300; #1; chk("R6 id repeat read", id_word, 16'h00C2);
    @(negedge clk);
    // R11 abort ignored while busy
    seq_busy = 1'b1;
    wr(20'h00000, 16'h00F0, 1'b0);
    seq_busy = 1'b0;
    bus_addr = 20'h00010; #1; chk("R11 busy F0 ignored", rd_sel, 1);
    @(negedge clk);
    wr(20'h00000, 16'h00F0, 1'b0);
    bus_addr = 20'h00000; #1;
    chk("R7 abort leaves ident", rd_sel, 0);
    chk("R6 id_word zero outside ident", id_word, 0);
    @(negedge clk);

    // R9 secure window boundary and R7 abort keeps secure mode
    unlock_cmd(8'h88);
    bus_addr = 20'h001FF; #1; chk("R9 secure last word", rd_sel, 2);
    bus_addr = 20'h00200; #1; chk("R9 above secure window", rd_sel, 0);
    @(negedge clk);
    wr(20'h00555, 16'h00F0, 1'b0);
    bus_addr = 20'h00000; #1; chk("R7 abort keeps secure", rd_sel, 2);
    do_reset();
    bus_addr = 20'h00000; #1; chk("R1 reset leaves secure", rd_sel, 0);
    @(negedge clk);

    // R4 accelerated programming
    accel_en = 1'b1;
    wr(20'h00555, 16'h00A0, 1'b0);
    wr(20'h00ABC, 16'h7E7E, 1'b0);
    accel_en = 1'b0;
    chk("R4 accel prog strobe", prog_req, 1);
    chk("R4 accel prog data", prog_data, 16'h7E7E);
    @(negedge clk);
    chk("R3 strobe one cycle", prog_req, 0);

    // R11 ignored first unlock while busy
    seq_busy = 1'b1;
    wr(20'h00555, 16'h00AA, 1'b0);
    seq_busy = 1'b0;
    wr(20'h002AA, 16'h0055, 1'b0);
    wr(20'h00555, 16'h00A0, 1'b0);
    wr(20'h00300, 16'h1111, 1'b0);
    chk("R11 busy unlock ignored", prog_req, 0);
    @(negedge clk);

    // R10 failure mode: only abort leaves it
    seq_fail = 1'b1; @(posedge clk); @(negedge clk); seq_fail = 1'b0;
    #1; chk("R10 fail status", rd_sel, 3);
    @(negedge clk);
    unlock_cmd(8'h90);
    #1; chk("R10 writes ignored in fail", rd_sel, 3);
    @(negedge clk);
    wr(20'h00000, 16'h00F0, 1'b0);
    #1; chk("R10 abort leaves fail", rd_sel, 0);
    @(negedge clk);

    // R10 same-cycle: failure report and abort write
    wr(20'h00000, 16'h00F0, 1'b1);
    #1; chk("R10 fail beats abort", rd_sel, 3);
    @(negedge clk);
    wr(20'h00000, 16'h00F0, 1'b0);
    #1; chk("R10 later abort exits", rd_sel, 0);
    @(negedge clk);

    // R2 output enable low blocks a write cycle
    bus_oe_n = 1'b0;
    wr(20'h00555, 16'h00AA, 1'b0);
    bus_oe_n = 1'b1;
    wr(20'h002AA, 16'h0055, 1'b0);
    wr(20'h00555, 16'h0090, 1'b0);
    #1; chk("R2 oe low blocks write", rd_sel, 0);

    finish_run();
  end

endmodule